// File: doc/BRIEF.md
# External Bus Cycle Wait-State Controller

This block sets the length and the data width of every external memory bus cycle. A requester offers a cycle on a valid/ready handshake. The controller then steps through an address phase and a data phase. Their lengths depend on a two-bit timing mode. After the data phase it may add one automatic wait clock, and then wait clocks driven by the external READY line, up to a programmed ceiling. It reports the final clock of each cycle with a one-clock strobe. It raises a stretch flag during every inserted wait clock. For the whole cycle it drives the effective data width, either fixed by configuration or taken from a width pin.

The configuration is split across two narrow write ports. The READY ceiling is a three-bit code, with two bits on port A and one bit on port B. The width choice is a two-bit code, with one bit on each port. A write on either port re-evaluates the combined codes. When a code is illegal, a sticky error flag is set. While that flag is set, cycles run with no READY wait clocks and a 16-bit width.

Back-pressure rules: a cycle is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no cycle is in flight. A requester that sees `req_ready` low keeps `req_valid` high until the cycle is accepted. The mode, ceiling and width are captured at acceptance, so later configuration writes apply to the next cycle only.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: During and right after reset, `req_ready`=1, `cyc_done`=0, `cyc_extend`=0, `bus_w8`=0 and `cfg_err`=0. The reset configuration is mode 11, ceiling code 000 and width code 01.
- R2: A cycle is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is 0 from the next clock until the clock that carries `cyc_done`, and it is 1 again on the following clock.
- R3: The timing mode is `cfg_b_wdata[1:0]`. Mode 11 gives 1 address clock and 1 data clock. Mode 00 gives 1 address clock, 1 data clock and then one automatic wait clock. Mode 01 gives 1 address clock and 2 data clocks. Mode 10 gives 2 address clocks and 2 data clocks. A cycle spans address + data + automatic + READY wait clocks + 1 final clock, counted from the first clock after acceptance and ending with the `cyc_done` clock.
- R4: The READY ceiling code is {`cfg_b_wdata[3]`, `cfg_a_wdata[2:1]`}. Code 000 allows no READY wait clocks. Codes 100, 101 and 110 allow at most 1, 2 and 3 READY wait clocks.
- R5: READY passes through one register before use. After the data phase (or after the automatic wait clock, if there is one), READY wait clocks start if the registered READY is low. If READY was low before acceptance and is raised after K READY wait clocks, the cycle holds min(K+1, ceiling) READY wait clocks. If READY stays low, the cycle holds the full ceiling.
- R6: Ceiling code 111 sets no bound. With READY raised after K wait clocks, the cycle holds exactly K+1 READY wait clocks.
- R7: The width code is {`cfg_b_wdata[2]`, `cfg_a_wdata[0]`}. Code 01 gives 16-bit (`bus_w8`=0) and code 10 gives 8-bit (`bus_w8`=1). With code 11, `width_pin` high means 16-bit and low means 8-bit.
- R8: With width code 11, `width_pin` is sampled at acceptance. `bus_w8` stays fixed for the whole cycle even if the pin changes.
- R9: `cfg_err` is set by a ceiling code 001, 010 or 011, or by width code 00. It is recomputed only on a configuration write, on the clock of the write. While it is set, cycles use no READY wait clocks and 16-bit width.
- R10: `cyc_done` is high for exactly one clock per cycle. `cyc_extend` is high exactly on the automatic and READY wait clocks, never together with `cyc_done` and never outside a cycle.
- R11: A configuration write during a cycle does not change the length or width of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a_we | input | 1 | Write strobe for configuration port A |
| cfg_a_wdata | input | 3 | [2:1] low ceiling bits, [0] low width bit |
| cfg_b_we | input | 1 | Write strobe for configuration port B |
| cfg_b_wdata | input | 4 | [3] high ceiling bit, [2] high width bit, [1:0] timing mode |
| req_valid | input | 1 | Requester offers a bus cycle |
| req_ready | output | 1 | Controller idle, can accept a cycle |
| rdy_in | input | 1 | External READY, low requests wait clocks |
| width_pin | input | 1 | External width select, high = 16-bit |
| cyc_extend | output | 1 | Current clock is an inserted wait clock |
| cyc_done | output | 1 | Final clock of the current cycle |
| bus_w8 | output | 1 | Effective width of current cycle, 1 = 8-bit |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The checker assumes that a requester holds `req_valid` high until it sees acceptance. The stimulus keeps to this by raising `req_valid` only while `req_ready` is high and dropping it on the clock after acceptance. READY and the width pin are treated as synchronous to the bus clock. The stimulus changes them only at falling edges, and it settles READY at least one clock before each request so that the registered copy matches the driven level. The unbounded ceiling needs READY to rise again, so the stimulus always releases READY after a set number of wait clocks when that code is active.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_AUTO = 3'd3,
    ST_WAIT = 3'd4,
    ST_FIN  = 3'd5
  } seq_state_e;

  // timing mode encodings (behaviour depends on these values)
  localparam logic [1:0] TM_PLUS1   = 2'b00;
  localparam logic [1:0] TM_LONG    = 2'b01;
  localparam logic [1:0] TM_LONG_EA = 2'b10;
  localparam logic [1:0] TM_STD     = 2'b11;

  typedef enum logic [1:0] {
    WS_16  = 2'd0,
    WS_8   = 2'd1,
    WS_PIN = 2'd2
  } width_sel_e;

  function automatic logic ceil_bad(input logic [2:0] code);
    return (code[2] == 1'b0) && (code[1:0] != 2'b00);
  endfunction

  function automatic logic width_bad(input logic [1:0] code);
    return code == 2'b00;
  endfunction

  function automatic logic ceil_unbounded(input logic [2:0] code);
    return code == 3'b111;
  endfunction

  // number of READY wait clocks allowed by a bounded code
  function automatic logic [1:0] ceil_count(input logic [2:0] code);
    logic [1:0] n;
    n = 2'd0;
    if (code[2] && code[1:0] != 2'b11) n = code[1:0] + 2'd1;
    return n;
  endfunction

  function automatic width_sel_e width_decode(input logic [1:0] code);
    width_sel_e w;
    case (code)
      2'b10:   w = WS_8;
      2'b11:   w = WS_PIN;
      default: w = WS_16;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_wait_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [2:0]       a_wdata,
  input  logic             b_we,
  input  logic [3:0]       b_wdata,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] ceil_o,
  output logic             unb_o,
  output width_sel_e       wsel_o,
  output logic             err_o
);

  logic [1:0] mode_q;
  logic [2:0] ceil_q;
  logic [1:0] width_q;
  logic       err_q;

  logic [2:0] ceil_n;
  logic [1:0] width_n;

  always_comb begin
    ceil_n  = ceil_q;
    width_n = width_q;
    if (a_we) begin
      ceil_n[1:0] = a_wdata[2:1];
      width_n[0]  = a_wdata[0];
    end
    if (b_we) begin
      ceil_n[2]  = b_wdata[3];
      width_n[1] = b_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TM_STD;
      ceil_q  <= 3'b000;
      width_q <= 2'b01;
      err_q   <= 1'b0;
    end else begin
      ceil_q  <= ceil_n;
      width_q <= width_n;
      if (b_we) mode_q <= b_wdata[1:0];
      if (a_we || b_we) err_q <= ceil_bad(ceil_n) || width_bad(width_n);
    end
  end

  assign mode_o = mode_q;
  assign ceil_o = CNT_W'(ceil_count(ceil_q));
  assign unb_o  = ceil_unbounded(ceil_q);
  assign wsel_o = width_decode(width_q);
  assign err_o  = err_q;

endmodule

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  output logic rdy_q
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= 1'b1;
        else        pipe_q <= rdy_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], rdy_in};
      end
    end
  endgenerate

  assign rdy_q = pipe_q[STAGES-1];

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_wait_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             rdy_q,
  input  logic             width_pin,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             unb_i,
  input  width_sel_e       wsel_i,
  input  logic             err_i,
  output logic             cyc_extend,
  output logic             cyc_done,
  output logic             bus_w8
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  seq_state_e       st_q;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_c;
  logic [CNT_W-1:0] ceil_c;
  logic             unb_c;
  logic             w8_q;

  logic addr_long, data_long, wait_go, wait_end, w8_pick;

  always_comb begin
    addr_long = (mode_c == TM_LONG_EA);
    data_long = (mode_c == TM_LONG) || (mode_c == TM_LONG_EA);
    wait_go   = !rdy_q && (unb_c || (ceil_c != '0));
    wait_end  = rdy_q || (!unb_c && (cnt_q == ceil_c));
    case (wsel_i)
      WS_8:    w8_pick = 1'b1;
      WS_PIN:  w8_pick = !width_pin;
      default: w8_pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      mode_c <= TM_STD;
      ceil_c <= '0;
      unb_c  <= 1'b0;
      w8_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            mode_c <= mode_i;
            ceil_c <= err_i ? '0 : ceil_i;
            unb_c  <= !err_i && unb_i;
            w8_q   <= !err_i && w8_pick;
            ph_q   <= 1'b0;
            st_q   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (addr_long && !ph_q) ph_q <= 1'b1;
          else begin
            ph_q <= 1'b0;
            st_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (data_long && !ph_q) ph_q <= 1'b1;
          else begin
            ph_q  <= 1'b0;
            cnt_q <= CNT_W'(1);
            if (mode_c == TM_PLUS1) st_q <= ST_AUTO;
            else                    st_q <= wait_go ? ST_WAIT : ST_FIN;
          end
        end
        ST_AUTO: begin
          cnt_q <= CNT_W'(1);
          st_q  <= wait_go ? ST_WAIT : ST_FIN;
        end
        ST_WAIT: begin
          if (wait_end) st_q <= ST_FIN;
          else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign cyc_extend = (st_q == ST_AUTO) || (st_q == ST_WAIT);
  assign cyc_done   = (st_q == ST_FIN);
  assign bus_w8     = w8_q;

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
  import xbus_wait_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int RDY_STAGES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_a_we,
  input  logic [2:0] cfg_a_wdata,
  input  logic       cfg_b_we,
  input  logic [3:0] cfg_b_wdata,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       rdy_in,
  input  logic       width_pin,
  output logic       cyc_extend,
  output logic       cyc_done,
  output logic       bus_w8,
  output logic       cfg_err
);

  logic [1:0]       mode_w;
  logic [CNT_W-1:0] ceil_w;
  logic             unb_w;
  width_sel_e       wsel_w;
  logic             rdy_s;

  xbus_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_we    (cfg_a_we),
    .a_wdata (cfg_a_wdata),
    .b_we    (cfg_b_we),
    .b_wdata (cfg_b_wdata),
    .mode_o  (mode_w),
    .ceil_o  (ceil_w),
    .unb_o   (unb_w),
    .wsel_o  (wsel_w),
    .err_o   (cfg_err)
  );

  xbus_ready_sync #(.STAGES(RDY_STAGES)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdy_in (rdy_in),
    .rdy_q  (rdy_s)
  );

  xbus_cycle_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rdy_q      (rdy_s),
    .width_pin  (width_pin),
    .mode_i     (mode_w),
    .ceil_i     (ceil_w),
    .unb_i      (unb_w),
    .wsel_i     (wsel_w),
    .err_i      (cfg_err),
    .cyc_extend (cyc_extend),
    .cyc_done   (cyc_done),
    .bus_w8     (bus_w8)
  );

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_a_we,
  input logic cfg_b_we,
  input logic req_valid,
  input logic req_ready,
  input logic cyc_extend,
  input logic cyc_done,
  input logic bus_w8,
  input logic cfg_err
);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  // R10
  extend_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_extend && cyc_done));

  // R10
  extend_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_extend |-> !req_ready);

  // R8
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && $past(!req_ready) |-> $stable(bus_w8));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_a_we && !cfg_b_we |=> $stable(cfg_err));

  // R9
  err_width16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && req_valid && req_ready |=> !bus_w8);

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_a_we   (cfg_a_we),
  .cfg_b_we   (cfg_b_we),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cyc_extend (cyc_extend),
  .cyc_done   (cyc_done),
  .bus_w8     (bus_w8),
  .cfg_err    (cfg_err)
);

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_a_we = 1'b0;
  logic [2:0] cfg_a_wdata = '0;
  logic       cfg_b_we = 1'b0;
  logic [3:0] cfg_b_wdata = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       rdy_in = 1'b1;
  logic       width_pin = 1'b1;
  logic       cyc_extend, cyc_done, bus_w8, cfg_err;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  xbus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_a_we(cfg_a_we), .cfg_a_wdata(cfg_a_wdata),
    .cfg_b_we(cfg_b_we), .cfg_b_wdata(cfg_b_wdata),
    .req_valid(req_valid), .req_ready(req_ready),
    .rdy_in(rdy_in), .width_pin(width_pin),
    .cyc_extend(cyc_extend), .cyc_done(cyc_done),
    .bus_w8(bus_w8), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_bad(input int l, input int b);
    return ((l >> 2) == 0 && (l & 3) != 0) || (b == 0);
  endfunction

  // drive both config ports for one clock; returns at the following negedge
  task automatic wr_cfg(input int m, input int l, input int b);
    cfg_a_we    = 1'b1;
    cfg_a_wdata = {l[1:0], b[0]};
    cfg_b_we    = 1'b1;
    cfg_b_wdata = {l[2], b[1], m[1:0]};
    @(negedge clk);
    cfg_a_we = 1'b0;
    cfg_b_we = 1'b0;
  endtask

  // one bus cycle; relk>=1 raises READY after relk READY wait clocks
  // midwr: write mode 11 / ceiling 000 / width 01 during the cycle (R11)
  task automatic run(input int m, input int l, input int b, input bit rdy,
                     input bit pin, input int relk, input bit midwr, input string tag);
    bit ill;
    int lim, a, d, au, waits, exp_len, exp_ext, len, ext;
    bit exp_w8, w8_ok, busy_ok;
    ill = is_bad(l, b);
    if (ill)        lim = 0;
    else if (l == 7) lim = -1;
    else if (l >= 4) lim = (l & 3) + 1;
    else            lim = 0;
    if (ill)         exp_w8 = 1'b0;
    else if (b == 2) exp_w8 = 1'b1;
    else if (b == 3) exp_w8 = !pin;
    else             exp_w8 = 1'b0;
    a  = (m == 2) ? 2 : 1;
    d  = (m == 1 || m == 2) ? 2 : 1;
    au = (m == 0) ? 1 : 0;
    if (rdy || lim == 0) waits = 0;
    else if (relk < 1)   waits = lim;
    else if (lim < 0)    waits = relk + 1;
    else                 waits = (relk + 1 < lim) ? relk + 1 : lim;
    exp_len = a + d + au + waits + 1;
    exp_ext = au + waits;

    rdy_in = rdy;
    width_pin = pin;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    width_pin = !pin;
    len = 0; ext = 0; w8_ok = 1'b1; busy_ok = 1'b1;
    while (len < 100) begin
      len++;
      if (cyc_extend) ext++;
      if (bus_w8 !== exp_w8) w8_ok = 1'b0;
      if (req_ready !== 1'b0) busy_ok = 1'b0;
      if (midwr && len == 1) begin
        cfg_a_we = 1'b1; cfg_a_wdata = 3'b001;
        cfg_b_we = 1'b1; cfg_b_wdata = 4'b0011;
      end
      if (midwr && len == 2) begin
        cfg_a_we = 1'b0; cfg_b_we = 1'b0;
      end
      if (cyc_done) break;
      if (!rdy_in && relk >= 1 && (ext - au) == relk) rdy_in = 1'b1;
      @(negedge clk);
    end
    cfg_a_we = 1'b0; cfg_b_we = 1'b0;
    check(len == exp_len, {"R3/R4/R5/R6 length ", tag}, len, exp_len);
    check(ext == exp_ext, {"R10 extend count ", tag}, ext, exp_ext);
    check(w8_ok, {"R7/R8 width ", tag}, bus_w8, exp_w8);
    check(busy_ok, {"R2 busy ", tag}, req_ready, 0);
    @(negedge clk);
    check(req_ready == 1'b1 && cyc_done == 1'b0, {"R2 idle after done ", tag}, req_ready, 1);
    rdy_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(cyc_done == 1'b0 && cyc_extend == 1'b0, "R1 done/extend", cyc_done, 0);
    check(bus_w8 == 1'b0, "R1 bus_w8", bus_w8, 0);
    check(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cfg_err == 1'b0, "R1 after release", req_ready, 1);
    // reset configuration: mode 11, ceiling 000, width 01
    run(3, 0, 1, 1'b0, 1'b0, -1, 1'b0, "R1 reset cfg");

    // sweep of all codes; R9 error state after every write
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 8; l++)
        for (int b = 0; b < 4; b++) begin
          wr_cfg(m, l, b);
          check(cfg_err == is_bad(l, b), "R9 cfg_err after write", cfg_err, is_bad(l, b));
          for (int r = 0; r < 2; r++)
            for (int p = 0; p < 2; p++)
              run(m, l, b, r[0], p[0],
                  (l == 7 && !is_bad(l, b) && r == 0) ? 2 : -1, 1'b0, "sweep");
        end

    // R5 R6: READY released after K wait clocks against each ceiling
    for (int l = 4; l < 8; l++)
      for (int k = 1; k < 5; k++) begin
        wr_cfg(3, l, 1);
        run(3, l, 1, 1'b0, 1'b1, k, 1'b0, "R5/R6 release");
      end
    wr_cfg(0, 6, 3);
    run(0, 6, 3, 1'b0, 1'b0, 1, 1'b0, "R5 release after auto");

    // R11: config written mid-cycle applies only to the next cycle
    wr_cfg(2, 6, 2);
    run(2, 6, 2, 1'b0, 1'b1, -1, 1'b1, "R11 mid-cycle write");
    check(cfg_err == 1'b0, "R11 cfg_err after mid write", cfg_err, 0);
    run(3, 0, 1, 1'b0, 1'b1, -1, 1'b0, "R11 next cycle");

    // R9 sticky: error held across cycles until a legal write
    wr_cfg(3, 1, 3);
    run(3, 1, 3, 1'b0, 1'b0, -1, 1'b0, "R9 error cycle");
    check(cfg_err == 1'b1, "R9 sticky across cycle", cfg_err, 1);
    wr_cfg(3, 4, 2);
    check(cfg_err == 1'b0, "R9 cleared by legal write", cfg_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule